// File: doc/BRIEF.md
# Supply Reset Supervisor with Ramp Watchdog

This block generates an active-low system reset for a digital subsystem. It takes two supply-status flags that have already been thresholded: one says the rail is above the level at which reset must assert, the other says it is above the higher level at which reset may be released. From the first moment the release flag is seen, a hold timer delays the end of reset. After release, a slow up-counting ramp watches a kick input. Falling edges on that input pull the ramp down so that it never reaches its top; if the ramp does reach the top, a short reset pulse is issued.

The hold timer also times the watchdog pulse. During the pulse it advances thirty steps per cycle, so the pulse always lasts one thirtieth of the power-up hold. The ramp accepts a kick only once it has climbed past an arming level of one fifth of its top. A kick does not zero the ramp: it counts the ramp back down to the arming level at ten times the climb rate. A disable input parks the ramp at zero while the supply stays healthy. The kick and disable inputs are synchronised with two flops each. The supply flags are taken as synchronous to the clock.

Top module: `rst_supervisor`

## Requirements
- R1: Out of reset, and while `sup_rel_ok_i` has not been seen high, `sys_rst_no` is 0 and both counters are zero.
- R2: `sys_rst_no` rises exactly HOLD_CNT+1 clock edges after the first edge that samples `sup_rel_ok_i` high (301 with defaults), provided the flag stays high.
- R3: If `sup_rel_ok_i` drops during the hold, the hold is abandoned, and the next release flag starts a full new delay.
- R4: After release, the ramp starts at zero and climbs one step every 10*MON_DIV cycles. With no accepted kick, `sys_rst_no` falls MON_TOP*10*MON_DIV cycles after the release edge (400 with defaults).
- R5: A kick is a 1-to-0 transition of `wd_kick_i`, taking effect on the third edge after the change. A kick is ignored while the ramp is below MON_TOP/5, and the reset timing does not change.
- R6: An accepted kick makes the ramp fall one step every MON_DIV cycles down to MON_TOP/5, after which it climbs again from that level.
- R7: A watchdog pulse holds `sys_rst_no` low for exactly HOLD_CNT/30 cycles (10 with defaults). The ramp is zero during the pulse and restarts from zero when the pulse ends.
- R8: When `sup_rst_ok_i` is low during monitoring or during a pulse, `sys_rst_no` is low after the next edge, and the block returns to its initial state.
- R9: While monitoring, a drop of `sup_rel_ok_i` alone, with `sup_rst_ok_i` still high, has no effect.
- R10: While synchronised `wd_dis_i` is high, the ramp is held at zero and `sys_rst_no` stays high. When it goes low, the ramp starts again from zero.
- R11: A disable that arrives during a watchdog pulse does not shorten the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block |
| sup_rst_ok_i | input | 1 | Supply is above the reset-assert level |
| sup_rel_ok_i | input | 1 | Supply is above the reset-release level |
| wd_kick_i | input | 1 | Watchdog kick; falling edges count |
| wd_dis_i | input | 1 | Watchdog disable, asynchronous |
| sys_rst_no | output | 1 | Active-low system reset |

## Verification
The ramp is exercised with no kicks, with a kick placed before the arming level, with a single kick after arming, and with two spaced kicks. Each pattern gives its own predicted time for the reset edge, so an ignored early kick, a kick that clears the ramp instead of ramping it down, and a wrong down-rate all move an observed edge. Supply patterns cover a hold that is aborted and then restarted, a drop of the release flag only, and a drop of the reset flag during monitoring and during a pulse. These separate the two thresholds and the abort paths. Disable is applied during monitoring and during a pulse, which shows whether the pulse is allowed to complete.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_HOLD  = 2'd1,
    ST_RUN   = 2'd2,
    ST_WDRST = 2'd3
  } rsv_state_e;

  // shared-timer step during the watchdog pulse (pulse = hold / ratio)
  localparam int unsigned PULSE_RATIO = 30;
  // ramp-down speed relative to ramp-up
  localparam int unsigned DOWN_RATIO  = 10;
  // arming level = top / ARM_DIV
  localparam int unsigned ARM_DIV     = 5;
endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {(STAGES*WIDTH){RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rsv_mon_ramp.sv
module rsv_mon_ramp
  import rsv_pkg::*;
#(
  parameter int unsigned MON_TOP = 20,
  parameter int unsigned MON_DIV = 2,
  localparam int unsigned UP_DIV  = MON_DIV * DOWN_RATIO,
  localparam int unsigned ARM_LVL = MON_TOP / ARM_DIV,
  localparam int unsigned MW      = $clog2(MON_TOP + 1),
  localparam int unsigned PW      = $clog2(UP_DIV)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          kick_i,
  output logic [MW-1:0] mon_o,
  output logic          down_o,
  output logic          top_o
);
  localparam logic [MW-1:0] ARM_V  = MW'(ARM_LVL);
  localparam logic [MW-1:0] TOP_M1 = MW'(MON_TOP - 1);
  localparam logic [PW-1:0] UP_END = PW'(UP_DIV - 1);
  localparam logic [PW-1:0] DN_END = PW'(MON_DIV - 1);

  logic [MW-1:0] mon_q;
  logic [PW-1:0] ps_q;
  logic          down_q;
  logic          up_tick, dn_tick, kick_ok;

  always_comb begin
    up_tick = run_i && !down_q && (ps_q == UP_END);
    dn_tick = run_i &&  down_q && (ps_q == DN_END);
    kick_ok = run_i && !down_q && kick_i && (mon_q >= ARM_V);
    top_o   = up_tick && !kick_ok && (mon_q == TOP_M1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mon_q  <= '0;
      ps_q   <= '0;
      down_q <= 1'b0;
    end else if (!run_i) begin
      mon_q  <= '0;
      ps_q   <= '0;
      down_q <= 1'b0;
    end else if (kick_ok) begin
      down_q <= 1'b1;
      ps_q   <= '0;
    end else if (top_o) begin
      mon_q <= '0;
      ps_q  <= '0;
    end else if (up_tick) begin
      mon_q <= mon_q + MW'(1);
      ps_q  <= '0;
    end else if (dn_tick) begin
      ps_q <= '0;
      if (mon_q <= ARM_V + MW'(1)) begin
        mon_q  <= ARM_V;
        down_q <= 1'b0;
      end else begin
        mon_q <= mon_q - MW'(1);
      end
    end else begin
      ps_q <= ps_q + PW'(1);
    end
  end

  assign mon_o  = mon_q;
  assign down_o = down_q;
endmodule

// File: rtl/rsv_ctrl.sv
module rsv_ctrl
  import rsv_pkg::*;
#(
  parameter int unsigned HOLD_CNT = 300,
  localparam int unsigned TW      = $clog2(HOLD_CNT + PULSE_RATIO + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sup_rst_ok_i,
  input  logic       sup_rel_ok_i,
  input  logic       top_i,
  output rsv_state_e state_o,
  output logic       rst_no
);
  localparam logic [TW-1:0] HOLD_V = TW'(HOLD_CNT);
  localparam logic [TW-1:0] STEP_P = TW'(PULSE_RATIO);

  rsv_state_e    state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          rst_q;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    unique case (state_q)
      ST_OFF: begin
        tmr_d = '0;
        if (sup_rel_ok_i) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (!sup_rel_ok_i) begin
          state_d = ST_OFF;
          tmr_d   = '0;
        end else if (tmr_q + TW'(1) >= HOLD_V) begin
          state_d = ST_RUN;
          tmr_d   = '0;
        end else begin
          tmr_d = tmr_q + TW'(1);
        end
      end
      ST_RUN: begin
        tmr_d = '0;
        if (!sup_rst_ok_i) state_d = ST_OFF;
        else if (top_i)    state_d = ST_WDRST;
      end
      ST_WDRST: begin
        if (!sup_rst_ok_i) begin
          state_d = ST_OFF;
          tmr_d   = '0;
        end else if (tmr_q + STEP_P >= HOLD_V) begin
          state_d = ST_RUN;
          tmr_d   = '0;
        end else begin
          tmr_d = tmr_q + STEP_P;
        end
      end
      default: begin
        state_d = ST_OFF;
        tmr_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      tmr_q   <= '0;
      rst_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      rst_q   <= (state_d == ST_RUN);
    end
  end

  assign state_o = state_q;
  assign rst_no  = rst_q;
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rsv_pkg::*;
#(
  parameter int unsigned HOLD_CNT = 300,
  parameter int unsigned MON_TOP  = 20,
  parameter int unsigned MON_DIV  = 2,
  localparam int unsigned MW      = $clog2(MON_TOP + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sup_rst_ok_i,
  input  logic sup_rel_ok_i,
  input  logic wd_kick_i,
  input  logic wd_dis_i,
  output logic sys_rst_no
);
  logic [1:0]    raw_in, syn_out;
  logic          kick_s, dis_s, kick_prev_q, kick_fall;
  logic          mon_run, mon_top, mon_down;
  logic [MW-1:0] mon_lvl;
  rsv_state_e    state;

  assign raw_in = {wd_dis_i, wd_kick_i};

  rsv_sync #(.WIDTH(2), .STAGES(2), .RST_VAL(1'b0)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_in),
    .q_o    (syn_out)
  );

  assign kick_s = syn_out[0];
  assign dis_s  = syn_out[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kick_prev_q <= 1'b0;
    else         kick_prev_q <= kick_s;
  end

  assign kick_fall = kick_prev_q & ~kick_s;
  assign mon_run   = (state == ST_RUN) && !dis_s;

  rsv_mon_ramp #(.MON_TOP(MON_TOP), .MON_DIV(MON_DIV)) u_ramp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (mon_run),
    .kick_i (kick_fall),
    .mon_o  (mon_lvl),
    .down_o (mon_down),
    .top_o  (mon_top)
  );

  rsv_ctrl #(.HOLD_CNT(HOLD_CNT)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sup_rst_ok_i (sup_rst_ok_i),
    .sup_rel_ok_i (sup_rel_ok_i),
    .top_i        (mon_top),
    .state_o      (state),
    .rst_no       (sys_rst_no)
  );
endmodule

// File: rtl/rst_supervisor_checker.sv
module rst_supervisor_checker
  import rsv_pkg::*;
#(
  parameter int unsigned MON_TOP  = 20,
  localparam int unsigned MW      = $clog2(MON_TOP + 1),
  localparam int unsigned ARM_LVL = MON_TOP / ARM_DIV
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sup_rst_ok_i,
  input logic          sup_rel_ok_i,
  input rsv_state_e    state,
  input logic [MW-1:0] mon_lvl,
  input logic          mon_down,
  input logic          dis_s,
  input logic          sys_rst_no
);
  assert_off_holds_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_OFF && !sup_rel_ok_i) |=> (state == ST_OFF && !sys_rst_no && mon_lvl == '0));

  assert_release_origin_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> ($past(state) == ST_HOLD || $past(state) == ST_WDRST));

  assert_ramp_bounded_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mon_lvl < MW'(MON_TOP));

  assert_down_above_arm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mon_down |-> mon_lvl >= MW'(ARM_LVL));

  assert_pulse_ramp_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WDRST && $past(state) == ST_WDRST) |-> mon_lvl == '0);

  assert_brownout_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sup_rst_ok_i && (state == ST_RUN || state == ST_WDRST)) |=> (!sys_rst_no && state == ST_OFF));

  assert_disable_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RUN && dis_s) |=> mon_lvl == '0);

  assert_pulse_completes_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WDRST && sup_rst_ok_i) |=> (state == ST_WDRST || state == ST_RUN));
endmodule

bind rst_supervisor rst_supervisor_checker #(.MON_TOP(MON_TOP)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sup_rst_ok_i (sup_rst_ok_i),
  .sup_rel_ok_i (sup_rel_ok_i),
  .state        (state),
  .mon_lvl      (mon_lvl),
  .mon_down     (mon_down),
  .dis_s        (dis_s),
  .sys_rst_no   (sys_rst_no)
);

// File: tb/rst_supervisor_bench.sv
module rst_supervisor_bench;
  localparam int HOLD = 300;
  localparam int TOP  = 20;
  localparam int DIV  = 2;
  localparam int UPD  = DIV * 10;
  localparam int ARM  = TOP / 5;
  localparam int PUL  = HOLD / 30;
  localparam int WDT  = TOP * UPD;

  typedef struct {
    int    cyc;
    bit    lvl;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sup_rst = 1'b0, sup_rel = 1'b0, kick = 1'b1, dis = 1'b0;
  logic sys_rst_no;

  int   cyc = 0;
  int   n_chk = 0, n_fail = 0;
  bit   last_lvl = 1'b0;
  bit   done = 1'b0;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rst_supervisor #(.HOLD_CNT(HOLD), .MON_TOP(TOP), .MON_DIV(DIV)) u_rst_supervisor (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .sup_rst_ok_i (sup_rst),
    .sup_rel_ok_i (sup_rel),
    .wd_kick_i    (kick),
    .wd_dis_i     (dis),
    .sys_rst_no   (sys_rst_no)
  );

  task automatic push(input int t, input bit l, input string tag);
    q.push_back('{cyc: t, lvl: l, tag: tag});
  endtask

  task automatic at(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic check_lvl(input bit exp, input string tag);
    n_chk++;
    if (sys_rst_no !== exp) begin
      n_fail++;
      $display("FAIL %s: cycle %0d sys_rst_no=%b expected %b", tag, cyc, sys_rst_no, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: every observed edge of sys_rst_no is popped against the queue
  always @(negedge clk) begin
    if (rst_ni && (sys_rst_no !== last_lvl)) begin
      n_chk++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected edge: cycle %0d level %b expected none", cyc, sys_rst_no);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.cyc != cyc || e.lvl != sys_rst_no) begin
          n_fail++;
          $display("FAIL %s: edge cycle %0d level %b expected cycle %0d level %b",
                   e.tag, cyc, sys_rst_no, e.cyc, e.lvl);
        end
      end
      last_lvl = sys_rst_no;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: cycle %0d run hung, expected completion", cyc);
    finish_run();
  end

  initial begin
    int r, k, m, d, u, x, y;
    at(3);
    check_lvl(1'b0, "R1 in reset");
    rst_ni = 1'b1;
    at(8);
    check_lvl(1'b0, "R1 supply low");

    // R2: power-up hold
    at(10);
    sup_rst = 1'b1; sup_rel = 1'b1;
    r = 10 + HOLD + 1;
    push(r, 1'b1, "R2");
    // R4/R7: no kick
    push(r + WDT, 1'b0, "R4");
    push(r + WDT + PUL, 1'b1, "R7");
    r = r + WDT + PUL;

    // R5: kick before arming is ignored
    at(r + 30); kick = 1'b0;
    at(r + 40); kick = 1'b1;
    push(r + WDT, 1'b0, "R5");
    push(r + WDT + PUL, 1'b1, "R7");
    r = r + WDT + PUL;

    // R6: one accepted kick ramps down to arming level
    at(r + 150); kick = 1'b0;
    k = r + 153; m = (k - 1 - r) / UPD; d = (m > ARM) ? m - ARM : 1;
    u = k + 2 * d * DIV / 2;
    u = k + d * DIV;
    push(u + (TOP - ARM) * UPD, 1'b0, "R6");
    push(u + (TOP - ARM) * UPD + PUL, 1'b1, "R7");
    at(r + 160); kick = 1'b1;
    r = u + (TOP - ARM) * UPD + PUL;

    // R6: two spaced kicks
    at(r + 150); kick = 1'b0;
    at(r + 160); kick = 1'b1;
    k = r + 153; m = (k - 1 - r) / UPD; d = (m > ARM) ? m - ARM : 1;
    u = k + d * DIV;
    at(r + 350); kick = 1'b0;
    k = r + 353; m = ARM + (k - 1 - u) / UPD; d = (m > ARM) ? m - ARM : 1;
    u = k + d * DIV;
    push(u + (TOP - ARM) * UPD, 1'b0, "R6");
    push(u + (TOP - ARM) * UPD + PUL, 1'b1, "R7");
    at(r + 360); kick = 1'b1;
    r = u + (TOP - ARM) * UPD + PUL;

    // R9: release flag dips while monitoring
    at(r + 20); sup_rel = 1'b0;
    at(r + 60); sup_rel = 1'b1;
    // R10: disable parks the ramp
    at(r + 100); dis = 1'b1;
    at(r + 700); check_lvl(1'b1, "R10 disabled");
    at(r + 1100); dis = 1'b0;
    push(r + 1102 + WDT, 1'b0, "R10");
    push(r + 1102 + WDT + PUL, 1'b1, "R7");
    r = r + 1102 + WDT + PUL;

    // R11: disable during the pulse
    push(r + WDT, 1'b0, "R4");
    push(r + WDT + PUL, 1'b1, "R11");
    at(r + WDT + 1); dis = 1'b1;
    at(r + WDT + 5); check_lvl(1'b0, "R11 mid pulse");

    // R8: reset flag drops while monitoring (disabled)
    at(r + 900); sup_rst = 1'b0; sup_rel = 1'b0;
    push(r + 901, 1'b0, "R8");

    // R3: aborted hold then full restart
    x = r + 1000;
    at(x); sup_rst = 1'b1; sup_rel = 1'b1;
    at(x + 100); sup_rel = 1'b0;
    at(x + 150); sup_rel = 1'b1;
    y = x + 150 + HOLD + 1;
    push(y, 1'b1, "R3");

    // R8: reset flag drops during a pulse
    at(y + 50); dis = 1'b0;
    push(y + 52 + WDT, 1'b0, "R4");
    at(y + 52 + WDT + 3); sup_rst = 1'b0; sup_rel = 1'b0;
    at(y + 52 + WDT + 30); check_lvl(1'b0, "R8 pulse abort");
    at(y + 52 + WDT + 60); check_lvl(1'b0, "R8 stays off");

    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      n_fail++;
      $display("FAIL %s: edge missing, actual none expected cycle %0d level %b", e.tag, e.cyc, e.lvl);
    end
    finish_run();
  end
endmodule